// File: doc/BRIEF.md
# Software-Enabled Profiling Counter Bank

This peripheral sits on a simple memory-mapped bus next to a processor and keeps a bank of counter pairs for timing software. Each slot is assigned to one function under study. Small driver calls at the function's entry and exit write the slot's control word. One enable bit lets a wide time counter accumulate system clocks. The other enable bit is edge-detected, so each switch from off to on adds one to a call counter. Software reads the counters back over the same bus to build a per-function profile of call counts and elapsed cycles.

The bus side has a word address, write data, read and write strobes and a synchronous chip reset. Read data is registered. A single clear register zeroes every counter at once and leaves the enables as they are, so measurement can restart without reprogramming the slots.

Top module: `profCounterBank`

## Requirements
- R1: The bank has 20 slots. Slot s owns word addresses 4*s+f, where f=0 is the control word, f=1 the hit count, f=2 the low 32 bits of the time count and f=3 its high 32 bits.
- R2: busRdData is registered. It shows the addressed word one cycle after a clock edge that samples busRd high, and it is zero after any edge that samples busRd low.
- R3: A write to a control word sets the time-enable from data bit 0 and the hit-enable from data bit 1, and ignores the other bits. Reading the control word returns the time-enable in bit 0, the hit-enable in bit 1 and zero elsewhere. The new enables take effect at the write edge.
- R4: The 32-bit hit count of a slot rises by exactly one for each 0-to-1 change of its hit-enable. Rewriting a hit-enable that is already 1 adds nothing.
- R5: The 64-bit time count of a slot rises by one on every clock edge at which its time-enable is 1, and holds otherwise.
- R6: A write of any nonzero value to word address 0x0100 zeroes every hit and time count at that edge, takes priority over any increment in the same cycle, and leaves all enables unchanged. A write of zero there has no effect.
- R7: While chipRst is high at a clock edge, all counts, all enables and busRdData become zero.
- R8: Reads of words that are not a slot word (including 0x0100) return zero. Writes to them, and writes to hit or time words, change nothing.
- R9: Slots are independent: activity in one slot never changes another slot's enables or counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all counting and bus accesses use its rising edge |
| chipRst | input | 1 | Synchronous active-high reset of counters, enables and read data |
| busAddr | input | 16 | Word address of the access |
| busWrData | input | 32 | Write data |
| busRd | input | 1 | Read strobe, one access per cycle it is high |
| busWr | input | 1 | Write strobe, one access per cycle it is high |
| busRdData | output | 32 | Registered read data |

## Verification
Read data appears one edge after the read strobe is sampled. A control write changes the enables at its own edge, so the first time increment and the hit increment both land on the following edge and can be seen by a read issued in the cycle after that. The bench keeps a behavioural model of counts and enables that it advances at every rising edge with the inputs it drove. It compares busRdData with the model's predicted word at the next falling edge, on every cycle, including the cycles with no read, where the expected value is zero. Stimulus changes only at falling edges, so the order of reads, writes and counting inside one edge never depends on scheduling.

// File: rtl/prof_pkg.sv
package prof_pkg;

  // Width of a slot index carried in the strobe struct (up to 256 slots).
  localparam int IDX_W = 8;

  // Word selector inside a slot; the map decodes these positions.
  typedef enum logic [1:0] {
    FLD_CTRL = 2'd0,
    FLD_HIT  = 2'd1,
    FLD_TLO  = 2'd2,
    FLD_THI  = 2'd3
  } field_e;

  // Strobes from the bus decoder to the counter datapath.
  typedef struct packed {
    logic             ctrlWr;
    logic [IDX_W-1:0] wrSlot;
    logic             timeEnVal;
    logic             hitEnVal;
    logic             clearAll;
    logic             rdHit;
    logic [IDX_W-1:0] rdSlot;
    field_e           rdField;
  } strobes_t;

endpackage

// File: rtl/profCtrl.sv
module profCtrl
  import prof_pkg::*;
#(
  parameter int NUM_SLOTS = 20,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int CLR_WORD  = 256
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRd,
  input  logic              busWr,
  output strobes_t          strb
);

  localparam int WORDS_PER_SLOT = 4;
  localparam int MAP_WORDS      = NUM_SLOTS * WORDS_PER_SLOT;

  logic              inSlotSpace;
  logic              isClearWord;
  logic [IDX_W-1:0]  slotIdx;
  field_e            fieldSel;

  assign inSlotSpace = int'(busAddr) < MAP_WORDS;
  assign isClearWord = int'(busAddr) == CLR_WORD;
  assign slotIdx     = IDX_W'(busAddr >> 2);
  assign fieldSel    = field_e'(busAddr[1:0]);

  always_comb begin
    strb           = '0;
    strb.wrSlot    = slotIdx;
    strb.rdSlot    = slotIdx;
    strb.rdField   = fieldSel;
    strb.timeEnVal = busWrData[0];
    strb.hitEnVal  = busWrData[1];
    // Only the control word of a slot is writable; counter words are read-only.
    strb.ctrlWr    = busWr && inSlotSpace && (fieldSel == FLD_CTRL);
    // Any nonzero value written to the clear word triggers the clear.
    strb.clearAll  = busWr && isClearWord && (|busWrData);
    strb.rdHit     = busRd && inSlotSpace;
  end

endmodule

// File: rtl/profSlot.sv
module profSlot #(
  parameter int HIT_W  = 32,
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              chipRst,
  input  logic              ctrlWr,
  input  logic              timeEnVal,
  input  logic              hitEnVal,
  input  logic              clearAll,
  output logic              timeEn,
  output logic              hitEn,
  output logic [HIT_W-1:0]  hitCount,
  output logic [TIME_W-1:0] timeCount
);

  logic hitEnQ;
  logic hitRise;

  assign hitRise = hitEn && !hitEnQ;

  // Enable bits and the delayed copy used for edge detection.
  always_ff @(posedge clk) begin
    if (chipRst) begin
      timeEn <= 1'b0;
      hitEn  <= 1'b0;
      hitEnQ <= 1'b0;
    end else begin
      hitEnQ <= hitEn;
      if (ctrlWr) begin
        timeEn <= timeEnVal;
        hitEn  <= hitEnVal;
      end
    end
  end

  // Counters: clear wins over any increment in the same cycle.
  always_ff @(posedge clk) begin
    if (chipRst || clearAll) begin
      hitCount  <= '0;
      timeCount <= '0;
    end else begin
      if (timeEn) begin
        timeCount <= timeCount + TIME_W'(1);
      end
      if (hitRise) begin
        hitCount <= hitCount + HIT_W'(1);
      end
    end
  end

endmodule

// File: rtl/profDatapath.sv
module profDatapath
  import prof_pkg::*;
#(
  parameter int NUM_SLOTS = 20,
  parameter int HIT_W     = 32,
  parameter int TIME_W    = 64,
  parameter int DATA_W    = 32
) (
  input  logic                                clk,
  input  logic                                chipRst,
  input  strobes_t                            strb,
  output logic [DATA_W-1:0]                   busRdData,
  output logic [NUM_SLOTS-1:0]                timeEnVec,
  output logic [NUM_SLOTS-1:0]                hitEnVec,
  output logic [NUM_SLOTS-1:0][HIT_W-1:0]     hitCountVec,
  output logic [NUM_SLOTS-1:0][TIME_W-1:0]    timeCountVec
);

  logic [DATA_W-1:0] selWord;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : gSlot
    logic slotWr;
    assign slotWr = strb.ctrlWr && (strb.wrSlot == IDX_W'(s));

    profSlot #(
      .HIT_W (HIT_W),
      .TIME_W(TIME_W)
    ) uSlot (
      .clk      (clk),
      .chipRst  (chipRst),
      .ctrlWr   (slotWr),
      .timeEnVal(strb.timeEnVal),
      .hitEnVal (strb.hitEnVal),
      .clearAll (strb.clearAll),
      .timeEn   (timeEnVec[s]),
      .hitEn    (hitEnVec[s]),
      .hitCount (hitCountVec[s]),
      .timeCount(timeCountVec[s])
    );
  end

  // Read selection over slots and fields.
  always_comb begin
    selWord = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (strb.rdSlot == IDX_W'(s)) begin
        unique case (strb.rdField)
          FLD_CTRL: selWord = DATA_W'({hitEnVec[s], timeEnVec[s]});
          FLD_HIT:  selWord = DATA_W'(hitCountVec[s]);
          FLD_TLO:  selWord = timeCountVec[s][DATA_W-1:0];
          FLD_THI:  selWord = DATA_W'(timeCountVec[s] >> DATA_W);
          default:  selWord = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (chipRst) begin
      busRdData <= '0;
    end else begin
      busRdData <= strb.rdHit ? selWord : '0;
    end
  end

endmodule

// File: rtl/profCounterBank.sv
module profCounterBank
  import prof_pkg::*;
#(
  parameter int NUM_SLOTS = 20,
  parameter int HIT_W     = 32,
  parameter int TIME_W    = 64,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int CLR_WORD  = 256
) (
  input  logic              clk,
  input  logic              chipRst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRd,
  input  logic              busWr,
  output logic [DATA_W-1:0] busRdData
);

  strobes_t                          strb;
  logic [NUM_SLOTS-1:0]              timeEnVec;
  logic [NUM_SLOTS-1:0]              hitEnVec;
  logic [NUM_SLOTS-1:0][HIT_W-1:0]   hitCountVec;
  logic [NUM_SLOTS-1:0][TIME_W-1:0]  timeCountVec;

  profCtrl #(
    .NUM_SLOTS(NUM_SLOTS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CLR_WORD (CLR_WORD)
  ) uCtrl (
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .busRd    (busRd),
    .busWr    (busWr),
    .strb     (strb)
  );

  profDatapath #(
    .NUM_SLOTS(NUM_SLOTS),
    .HIT_W    (HIT_W),
    .TIME_W   (TIME_W),
    .DATA_W   (DATA_W)
  ) uDatapath (
    .clk         (clk),
    .chipRst     (chipRst),
    .strb        (strb),
    .busRdData   (busRdData),
    .timeEnVec   (timeEnVec),
    .hitEnVec    (hitEnVec),
    .hitCountVec (hitCountVec),
    .timeCountVec(timeCountVec)
  );

endmodule

// File: rtl/profCounterBankChk.sv
module profCounterBankChk #(
  parameter int NUM_SLOTS = 20,
  parameter int HIT_W     = 32,
  parameter int TIME_W    = 64,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int CLR_WORD  = 256
) (
  input logic                               clk,
  input logic                               chipRst,
  input logic [ADDR_W-1:0]                  busAddr,
  input logic [DATA_W-1:0]                  busWrData,
  input logic                               busRd,
  input logic                               busWr,
  input logic [DATA_W-1:0]                  busRdData,
  input logic [NUM_SLOTS-1:0]               timeEnVec,
  input logic [NUM_SLOTS-1:0]               hitEnVec,
  input logic [NUM_SLOTS-1:0][HIT_W-1:0]    hitCountVec,
  input logic [NUM_SLOTS-1:0][TIME_W-1:0]   timeCountVec
);

  logic clearReq;
  logic mapped;

  assign clearReq = busWr && (int'(busAddr) == CLR_WORD) && (busWrData != '0);
  assign mapped   = int'(busAddr) < NUM_SLOTS * 4;

  // R2: no read strobe leaves the read data at zero
  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (chipRst)
    !busRd |=> (busRdData == '0));

  // R8: unmapped reads return zero
  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (chipRst)
    (busRd && !mapped) |=> (busRdData == '0));

  // R7: reset clears all state
  assert_reset_clears_R7: assert property (@(posedge clk)
    chipRst |=> (busRdData == '0 && timeEnVec == '0 && hitEnVec == '0 &&
                 hitCountVec == '0 && timeCountVec == '0));

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : gChk
    // R5: time count follows its enable
    assert_time_step_R5: assert property (@(posedge clk) disable iff (chipRst)
      (timeEnVec[s] && !clearReq) |=> (timeCountVec[s] == $past(timeCountVec[s]) + TIME_W'(1)));
    assert_time_hold_R5: assert property (@(posedge clk) disable iff (chipRst)
      (!timeEnVec[s] && !clearReq) |=> $stable(timeCountVec[s]));

    // R4: hit count moves only on a rising hit-enable
    assert_hit_step_R4: assert property (@(posedge clk) disable iff (chipRst)
      ($rose(hitEnVec[s]) && !clearReq) |=> (hitCountVec[s] == $past(hitCountVec[s]) + HIT_W'(1)));
    assert_hit_hold_R4: assert property (@(posedge clk) disable iff (chipRst)
      (!$rose(hitEnVec[s]) && !clearReq) |=> $stable(hitCountVec[s]));

    // R6: clear zeroes counts and keeps enables
    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (chipRst)
      clearReq |=> (hitCountVec[s] == '0 && timeCountVec[s] == '0));
    assert_clear_keeps_en_R6: assert property (@(posedge clk) disable iff (chipRst)
      (clearReq && !(busWr && mapped)) |=> ($stable(timeEnVec[s]) && $stable(hitEnVec[s])));
  end

endmodule

bind profCounterBank profCounterBankChk #(
  .NUM_SLOTS(NUM_SLOTS),
  .HIT_W    (HIT_W),
  .TIME_W   (TIME_W),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .CLR_WORD (CLR_WORD)
) uChk (
  .clk         (clk),
  .chipRst     (chipRst),
  .busAddr     (busAddr),
  .busWrData   (busWrData),
  .busRd       (busRd),
  .busWr       (busWr),
  .busRdData   (busRdData),
  .timeEnVec   (timeEnVec),
  .hitEnVec    (hitEnVec),
  .hitCountVec (hitCountVec),
  .timeCountVec(timeCountVec)
);

// File: tb/tb_profCounterBank.sv
`timescale 1ns/1ps
module tb_profCounterBank;

  localparam int SLOTS = 20;
  localparam int CLRW  = 256;

  logic        clk = 1'b0;
  logic        rstI = 1'b1;
  logic [15:0] addrI = '0;
  logic [31:0] dataI = '0;
  logic        rdI = 1'b0;
  logic        wrI = 1'b0;
  logic [31:0] busRdData;

  always #4 clk = ~clk;  // 125 MHz

  profCounterBank dut (
    .clk      (clk),
    .chipRst  (rstI),
    .busAddr  (addrI),
    .busWrData(dataI),
    .busRd    (rdI),
    .busWr    (wrI),
    .busRdData(busRdData)
  );

  // Behavioural reference state
  longint unsigned mTime[SLOTS];
  int unsigned     mHit[SLOTS];
  bit              mTe[SLOTS];
  bit              mHe[SLOTS];
  bit              mHeOld[SLOTS];
  logic [31:0]     expRead = '0;
  string           expTag = "R7";

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  task automatic modelEdge(input string tag);
    logic [31:0] nxt;
    bit clr;
    int a;
    a = int'(addrI);
    if (rstI) begin
      for (int s = 0; s < SLOTS; s++) begin
        mTime[s] = 0; mHit[s] = 0; mTe[s] = 0; mHe[s] = 0; mHeOld[s] = 0;
      end
      expRead = '0;
      expTag = "R7";
      return;
    end
    nxt = '0;
    if (!rdI) expTag = "R2";
    else if (a >= SLOTS * 4) expTag = "R8";
    else begin
      case (a % 4)
        0: begin nxt = {30'd0, mHe[a/4], mTe[a/4]}; expTag = "R3"; end
        1: begin nxt = mHit[a/4]; expTag = "R4"; end
        2: begin nxt = mTime[a/4][31:0]; expTag = "R5"; end
        default: begin nxt = mTime[a/4][63:32]; expTag = "R5"; end
      endcase
    end
    if (rdI && tag != "") expTag = tag;
    clr = wrI && a == CLRW && dataI != 0;
    for (int s = 0; s < SLOTS; s++) begin
      if (clr) begin
        mTime[s] = 0; mHit[s] = 0;
      end else begin
        if (mTe[s]) mTime[s] = mTime[s] + 1;
        if (mHe[s] && !mHeOld[s]) mHit[s] = mHit[s] + 1;
      end
      mHeOld[s] = mHe[s];
    end
    if (wrI && a < SLOTS * 4 && a % 4 == 0) begin
      mTe[a/4] = dataI[0];
      mHe[a/4] = dataI[1];
    end
    expRead = nxt;
  endtask

  task automatic busCycle(input bit rd, input bit wr, input logic [15:0] a,
                          input logic [31:0] d, input string tag);
    rdI = rd; wrI = wr; addrI = a; dataI = d;
    @(posedge clk);
    modelEdge(tag);
    @(negedge clk);
    nChk++;
    if (busRdData !== expRead) begin
      nFail++;
      $display("FAIL %s at %0t: got 0x%08h expected 0x%08h", expTag, $time, busRdData, expRead);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) busCycle(0, 0, 16'h0, 32'h0, "");
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    busCycle(1, 0, a, 32'h0, tag);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    busCycle(0, 1, a, d, "");
  endtask

  initial begin
    @(negedge clk);
    // R7: reads during reset return zero
    for (int i = 0; i < 3; i++) rd(16'd1, "R7");
    rstI = 1'b0;
    // R7: state after reset is zero
    rd(16'd0, "R7"); rd(16'd1, "R7"); rd(16'd2, "R7"); rd(16'd3, "R7");

    // R3/R4/R5: enable both on slot 0
    wr(16'd0, 32'h3);
    idle(4);
    rd(16'd1, "R4"); rd(16'd2, "R5"); rd(16'd3, "R5"); rd(16'd0, "R3");
    // R4: rewrite with hit-enable already set adds nothing
    wr(16'd0, 32'h3);
    idle(2);
    rd(16'd1, "R4");
    // R4: off then on counts once more
    wr(16'd0, 32'h1); wr(16'd0, 32'h3);
    idle(1);
    rd(16'd1, "R4"); rd(16'd0, "R3");
    // R5: time stops when disabled
    wr(16'd0, 32'h2);
    idle(3);
    rd(16'd2, "R5"); rd(16'd2, "R5");

    // R1: last slot at words 76..79
    wr(16'd76, 32'h1);
    idle(5);
    rd(16'd78, "R1"); rd(16'd79, "R1"); rd(16'd76, "R1");
    // R9: untouched slot stays at zero, slot 0 unaffected by slot 19
    rd(16'd21, "R9"); rd(16'd22, "R9"); rd(16'd0, "R9"); rd(16'd1, "R9");

    // R8: writes to counter words and unmapped words are ignored
    wr(16'd1, 32'h55); rd(16'd1, "R8");
    wr(16'd80, 32'h3); rd(16'd80, "R8");
    rd(16'h0200, "R8"); rd(16'hFFFF, "R8"); rd(16'h0100, "R8");
    rd(16'd2, "R8");

    // R3: only bits 1:0 matter
    wr(16'd0, 32'hFFFF_FFFC); rd(16'd0, "R3");
    wr(16'd0, 32'hFFFF_FFFF); rd(16'd0, "R3");
    idle(2);

    // R6: zero write has no effect, nonzero write clears and keeps enables
    wr(16'h0100, 32'h0); rd(16'd2, "R6");
    wr(16'h0100, 32'h1); rd(16'd2, "R6"); rd(16'd1, "R6"); rd(16'd0, "R6");
    rd(16'd76, "R6"); rd(16'd78, "R6");
    idle(3);
    rd(16'd2, "R6");
    wr(16'h0100, 32'h8000_0000); rd(16'd78, "R6");
    // R4 after clear: a new rising edge counts from zero
    wr(16'd0, 32'h1); wr(16'd0, 32'h2); idle(1); rd(16'd1, "R4");

    // R7: reset mid-run clears enables and counts
    rstI = 1'b1;
    idle(1);
    rstI = 1'b0;
    rd(16'd0, "R7"); rd(16'd78, "R7"); idle(2); rd(16'd2, "R7");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

endmodule